// File: doc/BRIEF.md
# Current-Polarity Register Selector for Complementary PWM Pairs

Each of three complementary PWM pairs has an even and an odd duty-value register. This block picks which of the two a pair uses, so the controller can cancel the voltage error that deadtime causes. The error depends on the direction of the load current. Pair A drives outputs 0 and 1, pair B drives 2 and 3, and pair C drives 4 and 5. Outputs 0, 2 and 4 are the top switches; outputs 1, 3 and 5 are the bottom switches.

The polarity can come from one of four sources, picked at run time by a 2-bit mode field:
- no correction;
- software bits, held in a buffer and applied at the cycle boundary;
- current-status inputs latched whenever both switches of a pair are off;
- current-status inputs sampled once per cycle, at a point that depends on whether the PWM is centre- or edge-aligned.

A current-status input is low for positive load current and high for negative load current. The PWM counter, the comparators and the deadtime generator are outside this block. They supply the strobes and the switch states.

Top module: `pwm_polsel`

## Requirements
- R1: With mode 00 (no correction), every bit of `sel_odd` is 0 (even register), whatever the other inputs and the stored state.
- R2: A pulse on `sw_wr_en` stores `sw_wr_pol`. `sw_pol_rd` shows the stored value from the next cycle on, even before that value is in effect. With no write, the stored value does not change.
- R3: With mode 01 (manual), `sel_odd[i]` is the software bit in effect for pair i (0 = even register, 1 = odd register). The bit in effect takes the stored value only on a clock edge where `cyc_start` is high. A write made in the same cycle as `cyc_start` takes effect at the following boundary.
- R4: The deadtime latch of pair i takes `cur_stat[i]` on every edge where `top_on[i]` and `bot_on[i]` are both low. When either switch is on in every cycle (0 % or 100 % duty), the latch keeps its old value.
- R5: With `center_al` high, the cycle-point latch takes `cur_stat` on edges where `half_cyc` is high, and `cyc_start` does not trigger it.
- R6: With `center_al` low, the cycle-point latch takes `cur_stat` on edges where `cyc_start` is high, whatever the switch states are.
- R7: On each edge with `cyc_start` high, the sampled selection of every pair is loaded from that edge's updated latch value. The source is the deadtime latch in mode 10 and the cycle-point latch otherwise. In modes 10 and 11, `sel_odd` shows the sampled selection (low current status → 0, high → 1), so it changes only at a boundary.
- R8: The mode field is not buffered. `sel_odd` follows a change of `corr_mode` in the same cycle.
- R9: Reset (`rst_n` low) clears the stored and in-effect software bits, both latches and the sampled selection, so `sel_odd` and `sw_pol_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| corr_mode | input | 2 | Correction mode: 00 none, 01 manual, 10 deadtime sample, 11 cycle-point sample |
| sw_wr_en | input | 1 | Write strobe for the software polarity bits |
| sw_wr_pol | input | 3 | Software polarity bits to store, one per pair |
| cur_stat | input | 3 | Current-status inputs, one per pair (low = positive current) |
| top_on | input | 3 | Top switch on, one per pair |
| bot_on | input | 3 | Bottom switch on, one per pair |
| cyc_start | input | 1 | Strobe at the PWM cycle boundary |
| half_cyc | input | 1 | Strobe at the PWM half-cycle point |
| center_al | input | 1 | 1 = centre-aligned PWM, 0 = edge-aligned PWM |
| sel_odd | output | 3 | Register selection per pair: 0 = even, 1 = odd |
| sw_pol_rd | output | 3 | Readback of the stored software bits |

## Verification
The bench writes software bits in the same cycle as a boundary strobe. A design that forwards the new value at once, instead of waiting one more boundary, shows it in `sel_odd` too early. It also holds a pair's switches so that one of them is always on, which models 0 % and 100 % duty. A deadtime latch that samples anyway would then follow `cur_stat`, while a correct one keeps its old value. It switches the alignment mode while half-cycle and boundary strobes arrive, and changes the mode field in the middle of a cycle. A design with the wrong strobe would sample at the wrong point, and one that buffers the mode field would lag `corr_mode` by a cycle.

// File: rtl/pwm_polsel_pkg.sv
package pwm_polsel_pkg;

  typedef enum logic [1:0] {
    CM_NONE     = 2'b00,
    CM_MANUAL   = 2'b01,
    CM_DEADTIME = 2'b10,
    CM_FIXED    = 2'b11
  } corr_mode_e;

  // Register choice for one pair: 0 = even register, 1 = odd register.
  function automatic logic pick_sel(corr_mode_e m, logic man_bit, logic smp_bit);
    case (m)
      CM_NONE:   pick_sel = 1'b0;
      CM_MANUAL: pick_sel = man_bit;
      default:   pick_sel = smp_bit;
    endcase
  endfunction

  // A latch's next value: it loads when its trigger is high, otherwise it holds.
  function automatic logic next_latch(logic take, logic din, logic held);
    next_latch = take ? din : held;
  endfunction

endpackage

// File: rtl/polsel_swbuf.sv
module polsel_swbuf #(
  parameter int NPAIR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPAIR-1:0] wr_pol,
  input  logic             cyc_start,
  output logic [NPAIR-1:0] buf_pol,
  output logic [NPAIR-1:0] man_pol
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_pol <= '0;
      man_pol <= '0;
    end else begin
      if (wr_en)     buf_pol <= wr_pol;
      // The boundary copies the value that was stored before this edge.
      if (cyc_start) man_pol <= buf_pol;
    end
  end

endmodule

// File: rtl/polsel_sampler.sv
module polsel_sampler
  import pwm_polsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur_stat,
  input  logic top_on,
  input  logic bot_on,
  input  logic smp_stb,
  input  logic cyc_start,
  input  logic use_dt,
  output logic dt_take,
  output logic dt_lat,
  output logic fx_lat,
  output logic smp_act
);

  logic dt_nxt;
  logic fx_nxt;
  logic src;

  // Both switches off: the pair is in deadtime.
  assign dt_take = ~top_on & ~bot_on;
  assign dt_nxt  = next_latch(dt_take, cur_stat, dt_lat);
  assign fx_nxt  = next_latch(smp_stb, cur_stat, fx_lat);
  assign src     = use_dt ? dt_nxt : fx_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_lat  <= 1'b0;
      fx_lat  <= 1'b0;
      smp_act <= 1'b0;
    end else begin
      dt_lat <= dt_nxt;
      fx_lat <= fx_nxt;
      if (cyc_start) smp_act <= src;
    end
  end

endmodule

// File: rtl/pwm_polsel.sv
module pwm_polsel
  import pwm_polsel_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       corr_mode,
  input  logic             sw_wr_en,
  input  logic [NPAIR-1:0] sw_wr_pol,
  input  logic [NPAIR-1:0] cur_stat,
  input  logic [NPAIR-1:0] top_on,
  input  logic [NPAIR-1:0] bot_on,
  input  logic             cyc_start,
  input  logic             half_cyc,
  input  logic             center_al,
  output logic [NPAIR-1:0] sel_odd,
  output logic [NPAIR-1:0] sw_pol_rd
);

  corr_mode_e       mode_e;
  logic             smp_stb;
  logic             use_dt;
  logic [NPAIR-1:0] man_pol;
  logic [NPAIR-1:0] dt_take;
  logic [NPAIR-1:0] dt_lat;
  logic [NPAIR-1:0] fx_lat;
  logic [NPAIR-1:0] smp_act;

  assign mode_e  = corr_mode_e'(corr_mode);
  // Centre-aligned PWM samples at the half cycle; edge-aligned PWM samples at the cycle end.
  assign smp_stb = center_al ? half_cyc : cyc_start;
  assign use_dt  = (mode_e == CM_DEADTIME);

  polsel_swbuf #(.NPAIR(NPAIR)) u_swbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sw_wr_en),
    .wr_pol    (sw_wr_pol),
    .cyc_start (cyc_start),
    .buf_pol   (sw_pol_rd),
    .man_pol   (man_pol)
  );

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    polsel_sampler u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur_stat  (cur_stat[i]),
      .top_on    (top_on[i]),
      .bot_on    (bot_on[i]),
      .smp_stb   (smp_stb),
      .cyc_start (cyc_start),
      .use_dt    (use_dt),
      .dt_take   (dt_take[i]),
      .dt_lat    (dt_lat[i]),
      .fx_lat    (fx_lat[i]),
      .smp_act   (smp_act[i])
    );
    // The mode is not buffered, so the output mux follows it directly.
    assign sel_odd[i] = pick_sel(mode_e, man_pol[i], smp_act[i]);
  end

endmodule

// File: rtl/pwm_polsel_chk.sv
module pwm_polsel_chk #(
  parameter int NPAIR = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       corr_mode,
  input logic             sw_wr_en,
  input logic [NPAIR-1:0] sw_wr_pol,
  input logic             cyc_start,
  input logic [NPAIR-1:0] sel_odd,
  input logic [NPAIR-1:0] sw_pol_rd,
  input logic [NPAIR-1:0] dt_take,
  input logic [NPAIR-1:0] dt_lat
);

  AST_NONE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_mode == 2'b00) |-> (sel_odd == '0)); // R1

  AST_RD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (sw_pol_rd == $past(sw_wr_pol))); // R2

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> $stable(sw_pol_rd)); // R2

  AST_MAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (corr_mode != 2'b01 || sel_odd == $past(sw_pol_rd))); // R3

  AST_MAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_mode == 2'b01 && !cyc_start) |=> (corr_mode != 2'b01 || $stable(sel_odd))); // R3

  AST_DT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_take == '0) |=> $stable(dt_lat)); // R4

  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_mode[1] && !cyc_start) |=> (!corr_mode[1] || $stable(sel_odd))); // R7

endmodule

bind pwm_polsel pwm_polsel_chk #(.NPAIR(NPAIR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .corr_mode (corr_mode),
  .sw_wr_en  (sw_wr_en),
  .sw_wr_pol (sw_wr_pol),
  .cyc_start (cyc_start),
  .sel_odd   (sel_odd),
  .sw_pol_rd (sw_pol_rd),
  .dt_take   (dt_take),
  .dt_lat    (dt_lat)
);

// File: tb/sim_pwm_polsel.sv
`timescale 1ns/1ps
module sim_pwm_polsel;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] corr_mode;
  logic       sw_wr_en;
  logic [2:0] sw_wr_pol, cur_stat, top_on, bot_on;
  logic       cyc_start, half_cyc, center_al;
  logic [2:0] sel_odd, sw_pol_rd;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model state
  logic [2:0] m_buf, m_man, m_dt, m_fx, m_act;

  always #2 clk = ~clk;

  pwm_polsel u0 (
    .clk(clk), .rst_n(rst_n), .corr_mode(corr_mode), .sw_wr_en(sw_wr_en),
    .sw_wr_pol(sw_wr_pol), .cur_stat(cur_stat), .top_on(top_on), .bot_on(bot_on),
    .cyc_start(cyc_start), .half_cyc(half_cyc), .center_al(center_al),
    .sel_odd(sel_odd), .sw_pol_rd(sw_pol_rd)
  );

  function automatic logic [2:0] exp_sel(logic [1:0] m, logic [2:0] man, logic [2:0] act);
    if (m == 2'b00)      return 3'b000;
    else if (m == 2'b01) return man;
    else                 return act;
  endfunction

  function automatic string tag_of(logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R3";
      2'b10: return "R4/R7";
      default: return center_al ? "R5/R7" : "R6/R7";
    endcase
  endfunction

  task automatic check3(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply one cycle of inputs at a negedge, advance the model, check after the posedge.
  task automatic step(logic [1:0] m, logic we, logic [2:0] wd, logic [2:0] cs_in,
                      logic [2:0] t, logic [2:0] b, logic cs, logic hc, logic ca,
                      string extra);
    logic [2:0] off, n_dt, n_fx, src;
    logic stb;
    corr_mode = m; sw_wr_en = we; sw_wr_pol = wd; cur_stat = cs_in;
    top_on = t; bot_on = b; cyc_start = cs; half_cyc = hc; center_al = ca;
    // R8: the mode is applied combinationally; check it before the edge
    #0.5;
    check3("R8", sel_odd, exp_sel(m, m_man, m_act));
    off  = ~t & ~b;
    n_dt = (off & cs_in) | (~off & m_dt);
    stb  = ca ? hc : cs;
    n_fx = stb ? cs_in : m_fx;
    src  = (m == 2'b10) ? n_dt : n_fx;
    @(posedge clk);
    if (cs) m_man = m_buf;
    if (we) m_buf = wd;
    m_dt = n_dt;
    m_fx = n_fx;
    if (cs) m_act = src;
    #1;
    check3({tag_of(m), extra}, sel_odd, exp_sel(m, m_man, m_act));
    check3("R2", sw_pol_rd, m_buf);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    corr_mode = 2'b01; sw_wr_en = 0; sw_wr_pol = 0; cur_stat = 3'b111;
    top_on = 0; bot_on = 0; cyc_start = 0; half_cyc = 0; center_al = 0;
    m_buf = 0; m_man = 0; m_dt = 0; m_fx = 0; m_act = 0;
    repeat (3) @(negedge clk);
    // R9: reset clears everything
    check3("R9", sel_odd, 3'b000);
    check3("R9", sw_pol_rd, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: a write shows in readback, but not in sel_odd until a boundary
    step(2'b01, 1, 3'b101, 0, 3'b001, 3'b010, 0, 0, 0, " write-no-boundary");
    check3("R3", sel_odd, 3'b000);
    check3("R2", sw_pol_rd, 3'b101);
    // a write in the same cycle as the boundary applies one boundary later
    step(2'b01, 1, 3'b010, 0, 3'b001, 3'b010, 1, 0, 0, " same-cycle write");
    check3("R3", sel_odd, 3'b101);
    step(2'b01, 0, 0, 0, 3'b001, 3'b010, 1, 0, 0, " next boundary");
    check3("R3", sel_odd, 3'b010);

    // R1: mode 00 forces even
    step(2'b00, 0, 0, 3'b111, 0, 0, 1, 0, 0, " none");
    check3("R1", sel_odd, 3'b000);

    // R4: deadtime latch of pair 0 takes 1, then 100% duty keeps it
    step(2'b10, 0, 0, 3'b111, 3'b000, 3'b000, 1, 0, 0, " dt latch");
    check3("R4", sel_odd, 3'b111);
    for (int k = 0; k < 4; k++)
      step(2'b10, 0, 0, 3'b000, 3'b111, 3'b000, (k == 3), 0, 0, " 100pct hold");
    check3("R4", sel_odd, 3'b111);

    // R5: centre-aligned samples on half cycle only
    step(2'b11, 0, 0, 3'b110, 3'b111, 3'b000, 0, 1, 1, " half sample");
    step(2'b11, 0, 0, 3'b001, 3'b111, 3'b000, 1, 0, 1, " boundary no sample");
    check3("R5", sel_odd, 3'b110);
    // R6: edge-aligned samples on the boundary, even at full duty
    step(2'b11, 0, 0, 3'b011, 3'b000, 3'b111, 1, 1, 0, " edge sample");
    check3("R6", sel_odd, 3'b011);
    // R8: mode change mid-cycle is seen at once
    step(2'b01, 0, 0, 0, 0, 0, 0, 0, 0, " mode change");
    check3("R8", sel_odd, 3'b010);

    // Constrained random stimulus
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] m;
      logic [2:0] t, b;
      m = corr_mode;
      if ($urandom_range(15) == 0) m = 2'($urandom_range(3));
      t = 3'($urandom);
      b = 3'($urandom) & ~t;   // complementary pair: never both on
      step(m, ($urandom_range(3) == 0), 3'($urandom), 3'($urandom), t, b,
           ($urandom_range(7) == 0), ($urandom_range(7) == 0),
           (n % 500) < 250 ? 1'b1 : 1'b0, " random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule